// File: doc/BRIEF.md
# Tick-Driven Timer with Two Compare Channels

The block is an 8-bit up-counter that advances once per tick and serves two compare channels, A and B. The tick is a single-cycle enable that has already been divided down elsewhere. A control field chooses one of two tick inputs, or no tick at all. When no tick is chosen, the counter is frozen. The wrap point, called the top, is either the full-scale value 0xFF or the active compare value of channel A.

Each channel holds two copies of its compare value. Software writes a buffered copy. The comparator uses an active copy, which is loaded either at once or when the counter wraps, depending on the mode. A tick that finds the counter equal to a channel's active value is a compare match. A match raises that channel's flag and moves its waveform output: in the toggle modes the output toggles, and in the fast PWM modes it is cleared. An overflow flag marks each wrap.

The three flags share one register. Each flag is gated by its own mask bit, and the gated flags are OR-ed into one interrupt line. Software reaches all registers through a write-only port with a valid/ready handshake. That port never applies back-pressure: `wr_ready_o` is held high, and every cycle with `wr_valid_i` high commits one write.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the count, flags, interrupt and both waveform outputs are 0, and no tick source is selected.
- R2: Control register (address 3) bits [3:2] select the tick: 01 uses `tick_int_i`, 10 uses `tick_ext_i`, and 00 or 11 selects nothing. With nothing selected the count is frozen and no flag is raised. Each selected tick adds one to the count.
- R3: Control bits [1:0] set the mode: 00 toggle with top 0xFF, 01 toggle with top equal to the active A value, 10 fast PWM with top 0xFF, 11 fast PWM with top equal to the active A value. A tick that finds the count equal to the top sets the count to 0x00 and sets the overflow flag (bit 0).
- R4: A tick that finds the count equal to a channel's active compare value sets flag bit 1 for channel A or flag bit 2 for channel B.
- R5: A write to address 1 (A) or address 2 (B) fills the buffer. In modes 00/01 the active copy is updated in the same cycle. In modes 10/11 the active copy is loaded from the buffer only on a wrapping tick.
- R6: In modes 00/01, a compare match toggles that channel's waveform output.
- R7: In modes 10/11, a wrapping tick sets the waveform output and a compare match clears it. If both happen on the same tick, the set wins.
- R8: Writing address 5 clears every flag whose data bit is 1. A flag that is set and cleared in the same cycle stays set.
- R9: Mask register (address 4) bit i enables flag bit i. `irq_o` is high exactly when some flag is set together with its mask bit.
- R10: A write to address 0 loads the count. A tick in that same cycle is ignored: it causes no increment, no match and no wrap.
- R11: `wr_ready_o` is always 1, and each cycle with `wr_valid_i` high commits exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_int_i | input | 1 | Internal prescaled tick |
| tick_ext_i | input | 1 | External tick, already synchronised |
| wr_valid_i | input | 1 | Register write request |
| wr_ready_o | output | 1 | Write accept, always high |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| count_o | output | 8 | Current count |
| flags_o | output | 3 | Flags: bit 0 overflow, bit 1 match A, bit 2 match B |
| irq_o | output | 1 | Masked interrupt request |
| wave_a_o | output | 1 | Channel A waveform |
| wave_b_o | output | 1 | Channel B waveform |

## Verification
The internal state becomes visible at the ports one edge after it goes wrong, because the count, the flags and the waveforms all come straight from registers.

- A wrong active compare copy shows up as a flag that appears or stays missing on the tick after a reload point. The stale-versus-new test in PWM mode forces this case.
- A wrong top shows up as the count failing to return to zero on the wrapping tick.
- Wrong priority between set and clear shows up as a flag or waveform bit in the wrong state on the first sample after that cycle.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_TOGGLE_MAX = 2'b00,
    MODE_TOGGLE_CMP = 2'b01,
    MODE_PWM_MAX    = 2'b10,
    MODE_PWM_CMP    = 2'b11
  } tct_mode_e;

  localparam logic [ADDR_W-1:0] ADDR_COUNT = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMPA  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 3'd5;

  localparam logic [1:0] CSEL_INT = 2'b01;
  localparam logic [1:0] CSEL_EXT = 2'b10;
endpackage

// File: rtl/tct_counter.sv
module tct_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap  = adv && (cnt_q == top);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (adv)   cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  // R2: without a tick or a load the count holds
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(cnt_q));
  // R3: the count returns to bottom after the top
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && cnt_q == top) |=> (cnt_q == '0));
  // R10: a load wins over a tick
  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/tct_channel.sv
module tct_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             pwm,
  input  logic             adv,
  input  logic             wrap,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmp_act,
  output logic             match,
  output logic             wave
);
  logic [CNT_W-1:0] buf_q, act_q;
  logic             wave_q;

  assign match   = adv && (count == act_q);
  assign cmp_act = act_q;
  assign wave    = wave_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_en) buf_q <= wr_val;
      if (!pwm && wr_en)   act_q <= wr_val;
      else if (pwm && wrap) act_q <= buf_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       wave_q <= 1'b0;
    else if (pwm) begin
      if (wrap)       wave_q <= 1'b1;
      else if (match) wave_q <= 1'b0;
    end else if (match) wave_q <= ~wave_q;
  end

  // R5: in PWM modes the active copy only moves on a wrap
  assert_act_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !wrap) |=> $stable(act_q));
  // R6: a match toggles the output in toggle modes
  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm && match) |=> (wave_q != $past(wave_q)));
  // R7: a wrap sets the output, winning over a match
  assert_pwm_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && wrap) |=> wave_q);
  assert_pwm_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && match && !wrap) |=> !wave_q);
endmodule

// File: rtl/tct_irq.sv
module tct_irq #(
  parameter int NFLG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLG-1:0] set,
  input  logic [NFLG-1:0] clr,
  input  logic [NFLG-1:0] mask,
  output logic [NFLG-1:0] flags,
  output logic            irq
);
  logic [NFLG-1:0] flg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= (flg_q & ~clr) | set;
  end

  assign flags = flg_q;
  assign irq   = |(flg_q & mask);

  // R8: set beats clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flg_q & $past(set)) == $past(set)));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~set)) |=> ((flg_q & $past(clr & ~set)) == '0));
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tct_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_int_i,
  input  logic              tick_ext_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [2:0]        flags_o,
  output logic              irq_o,
  output logic              wave_a_o,
  output logic              wave_b_o
);
  localparam int NCH  = 2;
  localparam int NFLG = NCH + 1;
  localparam logic [CNT_W-1:0] MAXV = '1;

  tct_mode_e        mode_q;
  logic [1:0]       csel_q;
  logic [NFLG-1:0]  mask_q;
  logic             wr_fire, ld, tick_sel, adv, wrap, pwm;
  logic [CNT_W-1:0] top, count;
  logic [CNT_W-1:0] cmp_act [NCH];
  logic [NCH-1:0]   match, wave;
  logic [NFLG-1:0]  set, clr, flags;

  assign wr_ready_o = 1'b1;
  assign wr_fire    = wr_valid_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_TOGGLE_MAX;
      csel_q <= 2'b00;
      mask_q <= '0;
    end else if (wr_fire) begin
      if (wr_addr_i == ADDR_CTRL) begin
        mode_q <= tct_mode_e'(wr_data_i[1:0]);
        csel_q <= wr_data_i[3:2];
      end
      if (wr_addr_i == ADDR_MASK) mask_q <= wr_data_i[NFLG-1:0];
    end
  end

  always_comb begin
    case (csel_q)
      CSEL_INT: tick_sel = tick_int_i;
      CSEL_EXT: tick_sel = tick_ext_i;
      default:  tick_sel = 1'b0;
    endcase
  end

  assign ld  = wr_fire && (wr_addr_i == ADDR_COUNT);
  assign adv = tick_sel && !ld;
  assign pwm = mode_q[1];
  assign top = mode_q[0] ? cmp_act[0] : MAXV;

  tct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(ld),
    .load_val(wr_data_i), .top(top), .count(count), .wrap(wrap)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(int'(ADDR_CMPA) + ch);
    tct_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_fire && (wr_addr_i == CH_ADDR)), .wr_val(wr_data_i),
      .pwm(pwm), .adv(adv), .wrap(wrap), .count(count),
      .cmp_act(cmp_act[ch]), .match(match[ch]), .wave(wave[ch])
    );
  end

  assign set = {match, wrap};
  assign clr = (wr_fire && wr_addr_i == ADDR_FLAGS) ? wr_data_i[NFLG-1:0] : '0;

  tct_irq #(.NFLG(NFLG)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(set), .clr(clr),
    .mask(mask_q), .flags(flags), .irq(irq_o)
  );

  assign count_o  = count;
  assign flags_o  = flags;
  assign wave_a_o = wave[0];
  assign wave_b_o = wave[1];

  // R2: with no source selected no flag rises
  assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csel_q != CSEL_INT && csel_q != CSEL_EXT) |=> ((flags & ~$past(flags)) == '0));
  // R9: interrupt needs a flag and its mask
  assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(flags_o & mask_q)));
  // R11: writes are never stalled
  assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n) wr_ready_o);
endmodule

// File: tb/tick_cmp_timer_bench.sv
module tick_cmp_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_int = 1'b0, tick_ext = 1'b0, wr_valid = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_ready, irq, wave_a, wave_b;
  logic [7:0] count;
  logic [2:0] flags;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tick_cmp_timer u_tick_cmp_timer (
    .clk(clk), .rst_n(rst_n), .tick_int_i(tick_int), .tick_ext_i(tick_ext),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .count_o(count), .flags_o(flags), .irq_o(irq),
    .wave_a_o(wave_a), .wave_b_o(wave_b)
  );

  // {tick_int, wr_valid, addr[3], data[8], exp_count[8], exp_flags[3], exp_waves{b,a}[2]}
  localparam logic [25:0] VEC [13] = '{
    {1'b0, 1'b1, 3'd3, 8'h04, 8'h00, 3'b000, 2'b00}, // R2 select internal tick
    {1'b0, 1'b1, 3'd1, 8'h02, 8'h00, 3'b000, 2'b00}, // R5 A = 2, immediate
    {1'b0, 1'b1, 3'd2, 8'h03, 8'h00, 3'b000, 2'b00}, // R5 B = 3
    {1'b1, 1'b0, 3'd0, 8'h00, 8'h01, 3'b000, 2'b00}, // R2 step
    {1'b1, 1'b0, 3'd0, 8'h00, 8'h02, 3'b000, 2'b00},
    {1'b1, 1'b0, 3'd0, 8'h00, 8'h03, 3'b010, 2'b01}, // R4 R6 match A
    {1'b1, 1'b0, 3'd0, 8'h00, 8'h04, 3'b110, 2'b11}, // R4 R6 match B
    {1'b0, 1'b1, 3'd5, 8'h02, 8'h04, 3'b100, 2'b11}, // R8 clear A
    {1'b0, 1'b1, 3'd0, 8'hFE, 8'hFE, 3'b100, 2'b11}, // R10 load
    {1'b1, 1'b0, 3'd0, 8'h00, 8'hFF, 3'b100, 2'b11},
    {1'b1, 1'b0, 3'd0, 8'h00, 8'h00, 3'b101, 2'b11}, // R3 wrap at 0xFF
    {1'b0, 1'b1, 3'd3, 8'h00, 8'h00, 3'b101, 2'b11}, // R2 deselect
    {1'b1, 1'b0, 3'd0, 8'h00, 8'h00, 3'b101, 2'b11}  // R2 frozen
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic ti, input logic te, input logic wv,
                      input logic [2:0] a, input logic [7:0] d);
    tick_int = ti; tick_ext = te; wr_valid = wv; wr_addr = a; wr_data = d;
    @(negedge clk);
    tick_int = 1'b0; tick_ext = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic tk();
    step(1'b1, 1'b0, 1'b0, 3'd0, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);
    chk("R1 waves", {wave_b, wave_a}, 0);
    chk("R11 ready", wr_ready, 1);
    tk();
    chk("R1 no source after reset", count, 0);

    for (int i = 0; i < 13; i++) begin
      step(VEC[i][25], 1'b0, VEC[i][24], VEC[i][23:21], VEC[i][20:13]);
      chk($sformatf("R4 table count %0d", i), count, VEC[i][12:5]);
      chk($sformatf("R4 table flags %0d", i), flags, VEC[i][4:2]);
      chk($sformatf("R6 table waves %0d", i), {wave_b, wave_a}, VEC[i][1:0]);
    end

    // R9 masking (flags = 101)
    wr(3'd4, 8'h01); chk("R9 ovf masked in", irq, 1);
    wr(3'd4, 8'h02); chk("R9 A clear flag", irq, 0);
    wr(3'd4, 8'h04); chk("R9 B masked in", irq, 1);
    wr(3'd4, 8'h00); chk("R9 all masked", irq, 0);

    // R8 set wins over clear
    wr(3'd5, 8'h07); chk("R8 clear all", flags, 0);
    wr(3'd3, 8'h04);
    wr(3'd1, 8'h05);
    wr(3'd0, 8'h05);
    step(1'b1, 1'b0, 1'b1, 3'd5, 8'h02);
    chk("R8 set wins", flags, 3'b010);
    chk("R6 A toggled low", wave_a, 0);
    chk("R2 count", count, 8'h06);

    // R10 tick ignored during a count load
    wr(3'd5, 8'h07);
    wr(3'd1, 8'h06);
    step(1'b1, 1'b0, 1'b1, 3'd0, 8'h20);
    chk("R10 load value", count, 8'h20);
    chk("R10 no match", flags, 0);

    // R2 external tick selection
    wr(3'd3, 8'h08);
    tk(); chk("R2 int ignored", count, 8'h20);
    step(1'b0, 1'b1, 1'b0, 3'd0, 8'h00); chk("R2 ext counts", count, 8'h21);
    wr(3'd3, 8'h0C);
    step(1'b0, 1'b1, 1'b0, 3'd0, 8'h00);
    tk(); chk("R2 code 11 frozen", count, 8'h21);

    // R3 top from compare A
    wr(3'd3, 8'h05);
    wr(3'd1, 8'h03);
    wr(3'd0, 8'h00);
    wr(3'd5, 8'h07);
    tk(); tk(); tk();
    chk("R3 reach top", count, 8'h03);
    tk();
    chk("R3 wrap at A", count, 8'h00);
    chk("R3 flags at wrap", flags, 3'b111);

    // R5/R7 fast PWM, buffered reload
    wr(3'd3, 8'h06);
    wr(3'd1, 8'h10);
    wr(3'd5, 8'h07);
    wr(3'd0, 8'h03);
    tk();
    chk("R5 old active A still used", flags, 3'b110);
    chk("R7 match clears A", wave_a, 0);
    wr(3'd0, 8'hFF);
    wr(3'd5, 8'h07);
    tk();
    chk("R7 wrap sets A", wave_a, 1);
    chk("R3 ovf in PWM", flags, 3'b001);
    wr(3'd5, 8'h07);
    wr(3'd0, 8'h03);
    tk();
    chk("R5 reload took new A", flags, 3'b100);
    chk("R7 A held high", wave_a, 1);
    wr(3'd0, 8'h10);
    tk();
    chk("R7 new A match clears", wave_a, 0);
    chk("R4 A flag", flags[1], 1);

    // R7 wrap and match on one tick: set wins
    chk("R7 B low before", wave_b, 0);
    wr(3'd3, 8'h04);
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'h06);
    wr(3'd0, 8'hFF);
    wr(3'd5, 8'h07);
    tk();
    chk("R7 set beats clear", wave_b, 1);
    chk("R4 B at top", flags, 3'b101);
    chk("R11 ready held", wr_ready, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule